// File: doc/BRIEF.md
# Aliased Status Register with Level Interrupt

This block holds one 64-bit status/control word on a simple request/response register port. Of the 64 bits only the top 16 are stored. The lower 48 bits always read back as zero. The most significant stored bit drives a level interrupt line.

The register can be reached at three consecutive word addresses:
- **Direct word:** plain read and write.
- **Second word:** modifies the stored value in place.
- **Third word:** modifies the stored value in place.

The parameter `CLR_VARIANT` selects the address set and the function of the second word:
- `CLR_VARIANT=0`: direct word 0x4020. The second word ANDs the write data into the register. The third word ORs it in.
- `CLR_VARIANT=1`: direct word 0x6080. The second word clears the register whatever the data is. The third word ORs the data in.

A word address is the byte address shifted right by three. Only aligned 8-byte accesses are meaningful. Any access that does not map to a supported operation is reported through a one-cycle unimplemented pulse. Such an access leaves the register unchanged.

Top module: `amisc_reg`

## Requirements
- R1: While reset is asserted and after it, the stored value is zero, `irq` is 0, and `rsp_valid` and `unimpl_pulse` are 0.
- R2: A request is decoded at word address `req_addr >> 3` only when `req_size` is 8 and `req_addr[2:0]` is 0. Any other request changes nothing and is treated as unmapped (R8, R9).
- R3: A write to the direct word stores `req_wdata & 64'hFFFF_0000_0000_0000` on the request's clock edge. A later read of the direct word returns the stored value, whose bits 47:0 are always zero.
- R4: A write to the OR word (direct+2) stores `(stored | req_wdata)`, masked to bits 63:48.
- R5: With `CLR_VARIANT=0`, a write to word direct+1 stores `(stored & req_wdata)`, masked to bits 63:48.
- R6: With `CLR_VARIANT=1`, a write to word direct+1 sets the stored value to zero whatever the data is.
- R7: `irq` equals bit 63 of the stored value from the cycle after each updating edge.
- R8: Every read request gives `rsp_valid` high for one cycle, one cycle after the request. The data is the stored value for the direct word and zero for any other address, including the two modifying words. Every read other than of the direct word also pulses `unimpl_pulse` in that same cycle.
- R9: A write to any address other than the three words leaves the stored value and `irq` unchanged. It pulses `unimpl_pulse` one cycle after the request. Writes produce no `rsp_valid`.
- R10: Cycles without `req_valid` leave the stored value unchanged and give no `rsp_valid` or `unimpl_pulse` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes (only 8 is valid) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Level interrupt, bit 63 of the stored value |
| unimpl_pulse | output | 1 | One-cycle pulse after an access to an unmapped address |

## Verification
The hardest state to reach is a register whose value and interrupt depend on a long chain of in-place updates. In such a chain, AND or clear operations are interleaved with OR operations, plus stray accesses that must leave the value untouched. The bench drives both variants from one shared request bus, so every address that one instance supports is an unmapped address for the other. It mixes aligned accesses to all six modifying and direct words with misaligned, wrong-size and random-address requests, using random data. This makes the interrupt bit toggle through every kind of update while reference models track both instances. Directed sequences first cover the AND chain that drops bit 63, the clear, and reads of the modifying words.

// File: rtl/amisc_pkg.sv
package amisc_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LOAD,
    OP_AND,
    OP_OR,
    OP_ZERO
  } amisc_op_e;

  // Word address of the direct location for each variant
  function automatic logic [15:0] base_word(input bit clr_variant);
    return clr_variant ? 16'h6080 : 16'h4020;
  endfunction

endpackage

// File: rtl/amisc_decode.sv
module amisc_decode
  import amisc_pkg::*;
#(
  parameter bit CLR_VARIANT = 1'b0,
  parameter int ADDR_W      = 20
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output amisc_op_e         wr_op,
  output logic              rd_any,
  output logic              rd_direct,
  output logic              unmapped
);

  localparam int WORD_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] W_DIRECT = WORD_W'(base_word(CLR_VARIANT));
  localparam logic [WORD_W-1:0] W_MODIFY = W_DIRECT + WORD_W'(1);
  localparam logic [WORD_W-1:0] W_OR     = W_DIRECT + WORD_W'(2);

  logic [WORD_W-1:0] word;
  logic              legal;
  amisc_op_e         modify_op;

  assign word  = req_addr[ADDR_W-1:3];
  assign legal = (req_size == 4'd8) && (req_addr[2:0] == 3'd0);

  generate
    if (CLR_VARIANT) begin : g_clear_alias
      assign modify_op = OP_ZERO;
    end else begin : g_and_alias
      assign modify_op = OP_AND;
    end
  endgenerate

  always_comb begin
    wr_op = OP_NONE;
    if (req_valid && req_write && legal) begin
      if (word == W_DIRECT)      wr_op = OP_LOAD;
      else if (word == W_MODIFY) wr_op = modify_op;
      else if (word == W_OR)     wr_op = OP_OR;
    end
  end

  assign rd_any    = req_valid && !req_write;
  assign rd_direct = rd_any && legal && (word == W_DIRECT);
  assign unmapped  = req_valid && !rd_direct && (wr_op == OP_NONE);

endmodule

// File: rtl/amisc_update.sv
module amisc_update
  import amisc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  amisc_op_e         op,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] nxt,
  output logic              upd_en
);

  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{KEEP_W{1'b1}}, {(DATA_W-KEEP_W){1'b0}}};

  logic [DATA_W-1:0] raw;

  always_comb begin
    case (op)
      OP_LOAD: raw = wdata;
      OP_AND:  raw = cur & wdata;
      OP_OR:   raw = cur | wdata;
      OP_ZERO: raw = '0;
      default: raw = cur;
    endcase
  end

  assign nxt    = raw & KEEP_MASK;
  assign upd_en = (op != OP_NONE);

endmodule

// File: rtl/amisc_reg.sv
module amisc_reg
  import amisc_pkg::*;
#(
  parameter bit CLR_VARIANT = 1'b0,
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 64,
  parameter int KEEP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq,
  output logic              unimpl_pulse
);

  localparam int WORD_W = ADDR_W - 3;
  localparam logic [WORD_W-1:0] W_DIRECT = WORD_W'(base_word(CLR_VARIANT));

  amisc_op_e         wr_op;
  logic              rd_any, rd_direct, unmapped, upd_en;
  logic [DATA_W-1:0] misc_q, misc_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rsp_valid_q, unimpl_q;

  amisc_decode #(.CLR_VARIANT(CLR_VARIANT), .ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .wr_op     (wr_op),
    .rd_any    (rd_any),
    .rd_direct (rd_direct),
    .unmapped  (unmapped)
  );

  amisc_update #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_update (
    .op     (wr_op),
    .cur    (misc_q),
    .wdata  (req_wdata),
    .nxt    (misc_d),
    .upd_en (upd_en)
  );

  always_comb begin
    rdata_d = rd_direct ? misc_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q      <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      unimpl_q    <= 1'b0;
    end else begin
      if (upd_en) misc_q <= misc_d;
      rdata_q     <= rdata_d;
      rsp_valid_q <= rd_any;
      unimpl_q    <= unmapped;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rdata_q;
  assign irq          = misc_q[DATA_W-1];
  assign unimpl_pulse = unimpl_q;

  // Port-level view of the request, used by the checks below
  logic [WORD_W-1:0] chk_word;
  logic              chk_legal_wr;
  assign chk_word     = req_addr[ADDR_W-1:3];
  assign chk_legal_wr = req_valid && req_write && (req_size == 4'd8) &&
                        (req_addr[2:0] == 3'd0);

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-KEEP_W-1:0] == '0));

  a_r4_or_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_legal_wr && chk_word == W_DIRECT + WORD_W'(2) && req_wdata[DATA_W-1])
    |=> irq);

  a_r8_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r9_write_no_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(misc_q) && !unimpl_pulse && !rsp_valid));

  generate
    if (CLR_VARIANT) begin : g_clear_check
      a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_legal_wr && chk_word == W_DIRECT + WORD_W'(1)) |=>
        (misc_q == '0 && !irq));
    end
  endgenerate

endmodule

// File: tb/test_amisc_reg.sv
`timescale 1ns/1ps
module test_amisc_reg;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]        req_size;
  logic [63:0]       req_wdata;
  logic              rsp_valid [2];
  logic [63:0]       rsp_rdata [2];
  logic              irq [2];
  logic              unimpl_pulse [2];

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 0;
  logic [63:0] model [2];

  always #2.5 clk = ~clk;

  amisc_reg #(.CLR_VARIANT(1'b0), .ADDR_W(ADDR_W)) i_amisc_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .irq(irq[0]),
    .unimpl_pulse(unimpl_pulse[0]));

  amisc_reg #(.CLR_VARIANT(1'b1), .ADDR_W(ADDR_W)) i_amisc_reg_clr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .irq(irq[1]),
    .unimpl_pulse(unimpl_pulse[1]));

  function automatic logic [ADDR_W-1:0] waddr(input logic [15:0] w);
    return ADDR_W'({w, 3'b000});
  endfunction

  function automatic logic [15:0] base_of(input int v);
    return (v == 1) ? 16'h6080 : 16'h4020;
  endfunction

  // 0 none, 1 direct, 2 modify word, 3 or word
  function automatic int slot(input int v, input logic [ADDR_W-1:0] a,
                              input logic [3:0] sz);
    logic [15:0] b;
    b = base_of(v);
    if (sz != 4'd8 || a[2:0] != 3'd0) return 0;
    if (a == waddr(b))           return 1;
    if (a == waddr(b + 16'd1))   return 2;
    if (a == waddr(b + 16'd2))   return 3;
    return 0;
  endfunction

  function automatic string tag_for(input int v, input bit w, input int s);
    if (s == 0) return w ? "R9/R2" : "R8/R2";
    if (!w)     return (s == 1) ? "R3" : "R8";
    if (s == 1) return "R3/R7";
    if (s == 3) return "R4/R7";
    return (v == 1) ? "R6/R7" : "R5/R7";
  endfunction

  task automatic check64(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one request after a falling edge, check both instances one cycle later
  task automatic do_req(input bit w, input logic [ADDR_W-1:0] a,
                        input logic [3:0] sz, input logic [63:0] d);
    int          s [2];
    logic [63:0] old [2];
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    for (int v = 0; v < 2; v++) begin
      s[v]   = slot(v, a, sz);
      old[v] = model[v];
      if (w) begin
        case (s[v])
          1: model[v] = d & 64'hFFFF_0000_0000_0000;
          2: model[v] = (v == 1) ? 64'd0 : (old[v] & d & 64'hFFFF_0000_0000_0000);
          3: model[v] = (old[v] | d) & 64'hFFFF_0000_0000_0000;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int v = 0; v < 2; v++) begin
      string t;
      bit    exp_unimpl;
      t = tag_for(v, w, s[v]);
      exp_unimpl = (s[v] == 0) || (!w && s[v] != 1);
      check64(unimpl_pulse[v] == exp_unimpl, t, "unimpl_pulse",
              64'(unimpl_pulse[v]), 64'(exp_unimpl));
      check64(rsp_valid[v] == !w, t, "rsp_valid", 64'(rsp_valid[v]), 64'(!w));
      check64(irq[v] == model[v][63], t, "irq", 64'(irq[v]), 64'(model[v][63]));
      if (!w)
        check64(rsp_rdata[v] == ((s[v] == 1) ? old[v] : 64'd0), t, "rsp_rdata",
                rsp_rdata[v], (s[v] == 1) ? old[v] : 64'd0);
    end
  endtask

  task automatic read_back(input int v);
    do_req(1'b0, waddr(base_of(v)), 4'd8, 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd5813);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = 4'd0; req_wdata = '0;
    model[0] = '0; model[1] = '0;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check64(!irq[v] && !rsp_valid[v] && !unimpl_pulse[v], "R1", "reset outputs",
              {61'd0, irq[v], rsp_valid[v], unimpl_pulse[v]}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset value reads as zero
    read_back(0); read_back(1);
    // R3: direct write masks to top 16 bits
    do_req(1'b1, waddr(16'h4020), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    do_req(1'b1, waddr(16'h6080), 4'd8, 64'h8123_4567_89AB_CDEF);
    read_back(0); read_back(1);
    // R5: AND chain drops bit 63 in the AND variant
    do_req(1'b1, waddr(16'h4021), 4'd8, 64'h7F0F_FFFF_FFFF_FFFF);
    read_back(0);
    // R6: clear ignores data
    do_req(1'b1, waddr(16'h6081), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    read_back(1);
    // R4: OR raises the interrupt
    do_req(1'b1, waddr(16'h4022), 4'd8, 64'h8000_0000_0000_0001);
    do_req(1'b1, waddr(16'h6082), 4'd8, 64'h8000_0000_0000_0000);
    // R8: reads of the modifying words return zero and pulse
    do_req(1'b0, waddr(16'h4021), 4'd8, 64'd0);
    do_req(1'b0, waddr(16'h6082), 4'd8, 64'd0);
    // R2/R9: wrong size and misaligned writes are ignored
    do_req(1'b1, waddr(16'h4020), 4'd4, 64'd0);
    do_req(1'b1, waddr(16'h6080) | ADDR_W'(4), 4'd8, 64'd0);
    do_req(1'b1, waddr(16'h1234), 4'd8, 64'd0);
    read_back(0); read_back(1);
    // R10: idle cycles
    repeat (3) begin
      @(negedge clk);
      for (int v = 0; v < 2; v++)
        check64(!unimpl_pulse[v] && !rsp_valid[v] && irq[v] == model[v][63], "R10",
                "idle", {62'd0, unimpl_pulse[v], rsp_valid[v]}, 64'd0);
    end
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [ADDR_W-1:0] a;
      logic [3:0]        sz;
      logic [63:0]       d;
      int                pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1, 2: a = waddr(16'h4020 + 16'($urandom_range(0, 2)));
        3, 4, 5: a = waddr(16'h6080 + 16'($urandom_range(0, 2)));
        6:       a = waddr(16'h4023);
        7:       a = waddr(16'h6080) | ADDR_W'($urandom_range(1, 7));
        default: a = ADDR_W'($urandom);
      endcase
      sz = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd8;
      d  = {$urandom, $urandom};
      do_req(1'($urandom_range(0, 1)), a, sz, d);
      if ($urandom_range(0, 4) == 0) @(negedge clk);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule